// File: doc/BRIEF.md
# Host-Slave Byte Mailbox

This block passes single bytes between a host bus agent and a local slave processor. The host deposits a byte into an inbound data register. The slave deposits a byte into an outbound data register. Each register has a full flag, and both flags sit in one status word that either side can observe. A side should consume a byte only once the matching flag says the producer has finished writing it. The flags are how the two sides avoid touching the same register at the same time.

The slave can arm a host interrupt. While it is armed, a full outbound register raises a level request toward an external serial interrupt encoder. The request goes away in hardware as soon as the host reads the outbound byte, so host software has no separate acknowledge step. Both sides talk to the block through single-cycle synchronous read and write strobes.

Top module: `hs_mailbox`

## Requirements
- R1: During and after a synchronous reset, every status bit is 0, `host_irq` is 0 and both data outputs read 0.
- R2: A host write strobe stores `h_wdata` in the inbound register. After that clock edge, `s_idr_data` shows the byte and inbound-full (status bit 0) is 1.
- R3: A slave inbound read strobe clears inbound-full on that same edge. If a host write lands in the same cycle, the write wins and the flag is 1.
- R4: A slave outbound write strobe stores `s_wdata`. After that edge, `h_odr_data` shows the byte and outbound-full (status bit 1) is 1.
- R5: A host outbound read strobe clears outbound-full. If a slave outbound write lands in the same cycle, the write wins and the flag is 1.
- R6: A slave outbound write while outbound-full is 1 and no host read is present replaces the byte, keeps the flag at 1 and sets overrun (status bit 2). A write accompanied by a host read does not set overrun.
- R7: Overrun holds until a slave control write with control bit 1 set. A control write with bit 1 clear leaves it unchanged.
- R8: Every slave control write loads control bit 0 into the interrupt enable (status bit 3).
- R9: `host_irq` is 1 exactly one cycle after outbound-full and the enable were both 1. It stays 0 while the enable is 0.
- R10: After a host outbound read with no slave outbound write, and no slave outbound write in the following cycle, `host_irq` is 0 in the cycle after that.
- R11: A host write while inbound-full is 1 replaces the inbound byte and keeps the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr_idr | input | 1 | Host write strobe for the inbound register |
| h_wdata | input | DATA_W | Host write byte |
| h_rd_odr | input | 1 | Host read strobe for the outbound register |
| h_odr_data | output | DATA_W | Outbound register contents |
| s_rd_idr | input | 1 | Slave read strobe for the inbound register |
| s_idr_data | output | DATA_W | Inbound register contents |
| s_wr_odr | input | 1 | Slave write strobe for the outbound register |
| s_wdata | input | DATA_W | Slave write byte |
| s_wr_ctl | input | 1 | Slave control write strobe |
| s_ctl_data | input | 2 | Bit 0 interrupt enable, bit 1 overrun clear |
| mbx_status | output | 4 | {enable, overrun, outbound-full, inbound-full} |
| host_irq | output | 1 | Registered level interrupt request |

## Verification
The assertions assume that every strobe is a clean single-cycle level that is sampled at the rising edge. They also assume that strobes are held low during reset, because several properties refer to the previous cycle's strobes. The bench drives all inputs at the falling edge, returns every strobe to 0 after one cycle, and keeps them all low while reset is applied. It exercises same-cycle collisions on purpose, so that the write-wins rule is checked alongside the properties.

// File: rtl/hs_mailbox_pkg.sv
package hs_mailbox_pkg;

    localparam int unsigned CTL_W   = 2;
    localparam int unsigned CTL_IEN = 0;
    localparam int unsigned CTL_OVC = 1;

    typedef struct packed {
        logic ien;
        logic ovr;
        logic obf;
        logic ibf;
    } mbx_status_t;

    // Next value of a full flag: a write always wins over a read.
    function automatic logic full_next(input logic full, input logic wr, input logic rd);
        return wr | (full & ~rd);
    endfunction

endpackage

// File: rtl/mbx_slot.sv
module mbx_slot #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] data,
    output logic         full
);
    import hs_mailbox_pkg::*;

    logic [W-1:0] data_q;
    logic         full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            full_q <= 1'b0;
        end else begin
            if (wr) data_q <= wdata;
            full_q <= full_next(full_q, wr, rd);
        end
    end

    assign data = data_q;
    assign full = full_q;

    // R2 / R4: a write always leaves the slot full
    p_full_after_write_r2: assert property (@(posedge clk) disable iff (rst)
        wr |=> full);
    // R3 / R5: a lone read empties the slot
    p_read_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (rd && !wr) |=> !full);
    // R11: without a write the stored byte does not move
    p_data_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(data));

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            ctl_wr,
    input  logic [hs_mailbox_pkg::CTL_W-1:0] ctl_data,
    input  logic                            ovr_evt,
    output logic                            ien,
    output logic                            ovr
);
    import hs_mailbox_pkg::*;

    logic ien_q, ovr_q, ovr_clr;

    assign ovr_clr = ctl_wr & ctl_data[CTL_OVC];

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            if (ctl_wr) ien_q <= ctl_data[CTL_IEN];
            ovr_q <= ovr_evt | (ovr_q & ~ovr_clr);
        end
    end

    assign ien = ien_q;
    assign ovr = ovr_q;

    p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (ovr && !ovr_clr) |=> ovr);
    p_ovr_set_r6: assert property (@(posedge clk) disable iff (rst)
        ovr_evt |=> ovr);
    p_ien_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !ctl_wr |=> $stable(ien));

endmodule

// File: rtl/mbx_irq.sv
module mbx_irq (
    input  logic clk,
    input  logic rst,
    input  logic ien,
    input  logic obf,
    output logic irq
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= ien & obf;
    end

    assign irq = irq_q;

    p_irq_needs_src_r9: assert property (@(posedge clk) disable iff (rst)
        (!ien || !obf) |=> !irq);

endmodule

// File: rtl/hs_mailbox.sv
module hs_mailbox #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_wr_idr,
    input  logic [DATA_W-1:0] h_wdata,
    input  logic              h_rd_odr,
    output logic [DATA_W-1:0] h_odr_data,
    input  logic              s_rd_idr,
    output logic [DATA_W-1:0] s_idr_data,
    input  logic              s_wr_odr,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic              s_wr_ctl,
    input  logic [1:0]        s_ctl_data,
    output logic [3:0]        mbx_status,
    output logic              host_irq
);
    import hs_mailbox_pkg::*;

    mbx_status_t st;
    logic        ibf, obf, ien, ovr, ovr_evt;

    mbx_slot #(.W(DATA_W)) u_in_slot (
        .clk(clk), .rst(rst), .wr(h_wr_idr), .wdata(h_wdata),
        .rd(s_rd_idr), .data(s_idr_data), .full(ibf)
    );

    mbx_slot #(.W(DATA_W)) u_out_slot (
        .clk(clk), .rst(rst), .wr(s_wr_odr), .wdata(s_wdata),
        .rd(h_rd_odr), .data(h_odr_data), .full(obf)
    );

    assign ovr_evt = s_wr_odr & obf & ~h_rd_odr;

    mbx_ctrl u_ctrl (
        .clk(clk), .rst(rst), .ctl_wr(s_wr_ctl), .ctl_data(s_ctl_data),
        .ovr_evt(ovr_evt), .ien(ien), .ovr(ovr)
    );

    mbx_irq u_irq (
        .clk(clk), .rst(rst), .ien(ien), .obf(obf), .irq(host_irq)
    );

    always_comb begin
        st.ibf = ibf;
        st.obf = obf;
        st.ovr = ovr;
        st.ien = ien;
    end
    assign mbx_status = st;

    p_irq_asserts_r9: assert property (@(posedge clk) disable iff (rst)
        (obf && ien) |=> host_irq);
    p_irq_hw_clear_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(h_rd_odr && !s_wr_odr) && !s_wr_odr) |=> !host_irq);
    p_collide_write_wins_r3: assert property (@(posedge clk) disable iff (rst)
        (h_wr_idr && s_rd_idr) |=> ibf);
    p_no_ovr_on_read_r6: assert property (@(posedge clk) disable iff (rst)
        (!ovr && (!s_wr_odr || h_rd_odr || !obf)) |=> !ovr);

endmodule

// File: tb/test_hs_mailbox.sv
module test_hs_mailbox;

    localparam int unsigned DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          h_wr_idr = 1'b0, h_rd_odr = 1'b0;
    logic [DW-1:0] h_wdata = '0, s_wdata = '0;
    logic          s_rd_idr = 1'b0, s_wr_odr = 1'b0, s_wr_ctl = 1'b0;
    logic [1:0]    s_ctl_data = '0;
    logic [DW-1:0] h_odr_data, s_idr_data;
    logic [3:0]    mbx_status;
    logic          host_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    hs_mailbox #(.DATA_W(DW)) i_hs_mailbox (
        .clk(clk), .rst(rst),
        .h_wr_idr(h_wr_idr), .h_wdata(h_wdata), .h_rd_odr(h_rd_odr),
        .h_odr_data(h_odr_data), .s_rd_idr(s_rd_idr), .s_idr_data(s_idr_data),
        .s_wr_odr(s_wr_odr), .s_wdata(s_wdata), .s_wr_ctl(s_wr_ctl),
        .s_ctl_data(s_ctl_data), .mbx_status(mbx_status), .host_irq(host_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One cycle of strobes, driven at the falling edge; returns after the next falling edge.
    task automatic step(input logic hw, input logic [DW-1:0] hd, input logic hr,
                        input logic sr, input logic sw, input logic [DW-1:0] sd,
                        input logic cw, input logic [1:0] cd);
        h_wr_idr = hw; h_wdata = hd; h_rd_odr = hr;
        s_rd_idr = sr; s_wr_odr = sw; s_wdata = sd;
        s_wr_ctl = cw; s_ctl_data = cd;
        @(negedge clk);
        h_wr_idr = 0; h_rd_odr = 0; s_rd_idr = 0; s_wr_odr = 0; s_wr_ctl = 0;
    endtask

    task automatic idle();
        step(0, '0, 0, 0, 0, '0, 0, 2'b00);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 status in reset", mbx_status, 4'h0);
        chk("R1 irq in reset", host_irq, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 status", mbx_status, 4'h0);
        chk("R1 irq", host_irq, 0);
        chk("R1 inbound data", s_idr_data, 8'h00);
        chk("R1 outbound data", h_odr_data, 8'h00);
    endtask

    task automatic t_inbound();
        step(1, 8'hA5, 0, 0, 0, '0, 0, 2'b00);
        chk("R2 inbound full", mbx_status[0], 1);
        chk("R2 inbound data", s_idr_data, 8'hA5);
        step(1, 8'h3C, 0, 0, 0, '0, 0, 2'b00);
        chk("R11 overwrite data", s_idr_data, 8'h3C);
        chk("R11 flag kept", mbx_status[0], 1);
        step(0, '0, 0, 1, 0, '0, 0, 2'b00);
        chk("R3 read clears", mbx_status[0], 0);
        step(1, 8'h81, 0, 1, 0, '0, 0, 2'b00);
        chk("R3 collision write wins", mbx_status[0], 1);
        chk("R3 collision data", s_idr_data, 8'h81);
        step(0, '0, 0, 1, 0, '0, 0, 2'b00);
        chk("R3 cleared again", mbx_status[0], 0);
    endtask

    task automatic t_outbound();
        step(0, '0, 0, 0, 1, 8'h5A, 0, 2'b00);
        chk("R4 outbound full", mbx_status[1], 1);
        chk("R4 outbound data", h_odr_data, 8'h5A);
        idle();
        chk("R9 no irq while disabled", host_irq, 0);
        step(0, '0, 0, 0, 1, 8'h77, 0, 2'b00);
        chk("R6 overwrite data", h_odr_data, 8'h77);
        chk("R6 flag kept", mbx_status[1], 1);
        chk("R6 overrun set", mbx_status[2], 1);
        step(0, '0, 1, 0, 0, '0, 0, 2'b00);
        chk("R5 host read clears", mbx_status[1], 0);
        step(0, '0, 0, 0, 0, '0, 1, 2'b00);
        chk("R7 overrun kept", mbx_status[2], 1);
        step(0, '0, 0, 0, 0, '0, 1, 2'b10);
        chk("R7 overrun cleared", mbx_status[2], 0);
        step(0, '0, 0, 0, 1, 8'h10, 0, 2'b00);
        step(0, '0, 1, 0, 1, 8'h22, 0, 2'b00);
        chk("R5 collision write wins", mbx_status[1], 1);
        chk("R5 collision data", h_odr_data, 8'h22);
        chk("R6 no overrun with read", mbx_status[2], 0);
        step(0, '0, 1, 0, 0, '0, 0, 2'b00);
        chk("R5 emptied", mbx_status[1], 0);
    endtask

    task automatic t_irq();
        step(0, '0, 0, 0, 0, '0, 1, 2'b01);
        chk("R8 enable set", mbx_status[3], 1);
        chk("R8 irq idle", host_irq, 0);
        step(0, '0, 0, 0, 1, 8'h11, 0, 2'b00);
        chk("R9 irq lags one cycle", host_irq, 0);
        idle();
        chk("R9 irq raised", host_irq, 1);
        step(0, '0, 1, 0, 0, '0, 0, 2'b00);
        chk("R10 flag cleared", mbx_status[1], 0);
        chk("R10 irq still high", host_irq, 1);
        idle();
        chk("R10 irq cleared by read", host_irq, 0);
        step(0, '0, 0, 0, 1, 8'h12, 0, 2'b00);
        idle();
        chk("R9 irq raised again", host_irq, 1);
        step(0, '0, 0, 0, 0, '0, 1, 2'b00);
        chk("R8 enable cleared", mbx_status[3], 0);
        idle();
        chk("R9 irq off with enable off", host_irq, 0);
        chk("R9 flag still full", mbx_status[1], 1);
        step(0, '0, 1, 0, 0, '0, 0, 2'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_inbound();
        t_outbound();
        t_irq();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule